// File: doc/BRIEF.md
# Dual-Path Host Byte Port

This block connects an external 8-bit asynchronous host bus to logic inside the chip. The host drives active-low chip select, write strobe and read strobe, a single address line and a byte of data. All of these are brought into the system clock through two-flop synchronisers. A write counts as complete when the block sees the synchronised write strobe rise while chip select is low.

The address line picks one of two host locations. With the address line low, the host writes an index byte. Bit 7 of that byte picks the destination path, and bits 6:0 give an internal register number. With the address line high, the host writes a data byte, which goes to the path the index selects:
- **Immediate path.** The byte and the register number are queued in a 64-entry FIFO. The block hands them to the internal register bus as soon as that bus accepts them.
- **Delayed path.** The byte is passed through a one-entry slot to a sequencer, using a valid/ready handshake. The sequencer applies it later.

Host reads do not go through any queue. With the address line low, a read returns a status byte. With it high, a read returns the value of the internal register named by the index.

The bus is split into an input byte, an output byte and an output enable, so that the pad cell sits outside the block.

Top module: `host_port_bridge`

## Requirements
- R1: After reset, bus_oe, reg_wr_valid and seq_valid are 0, and the status byte reads 0x01 (idle only).
- R2: A write with a0=0 loads the index register. reg_rd_addr always shows index bits 6:0.
- R3: A data write (a0=1) with index bit 7 = 0 appears on reg_wr_addr/reg_wr_data with reg_wr_valid. Entries come out in write order, and each is held stable until reg_wr_ready is high.
- R4: The immediate queue holds 64 entries plus one presented on the register bus. Status bit 1 reads 1 while the queue is full.
- R5: An immediate data write that arrives while the queue is full is discarded and sets the sticky overflow flag, status bit 3.
- R6: A status read returns the overflow flag and then clears it, so the next status read shows bit 3 = 0.
- R7: A data write with index bit 7 = 1 is presented on seq_data with seq_valid, held until seq_ready is high, and never reaches the register bus.
- R8: A delayed data write that arrives while the slot still holds an unaccepted byte is discarded and sets the overflow flag. Status bit 2 reads 1 while the slot is occupied or seq_ready is low.
- R9: A read with a0=1 returns reg_rd_data for the register named by index bits 6:0.
- R10: bus_oe is high only when chip select and read strobe were both low three clock cycles earlier. Strobes given while chip select is high change nothing.
- R11: A write takes effect only after the write strobe rises. Nothing reaches either path while the strobe is held low.
- R12: Status bit 0 reads 1 when the immediate queue is empty and no entry is waiting on the register bus. Bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| a0 | input | 1 | Host address line: 0 = index/status, 1 = data |
| bus_din | input | 8 | Byte driven by the host |
| bus_dout | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | Enable for the external data pad driver |
| reg_wr_valid | output | 1 | Immediate register write pending |
| reg_wr_ready | input | 1 | Register bus accepts the pending write |
| reg_wr_addr | output | 7 | Register number of the pending write |
| reg_wr_data | output | 8 | Data of the pending write |
| reg_rd_addr | output | 7 | Register number for host reads |
| reg_rd_data | input | 8 | Register value for reg_rd_addr |
| seq_valid | output | 1 | Byte offered to the sequencer |
| seq_ready | input | 1 | Sequencer accepts the offered byte |
| seq_data | output | 8 | Byte for the sequencer |

## Verification
The bench holds the register bus off while it writes 66 bytes. A design that miscounts its storage will raise the full flag too early or too late, or will keep the 66th byte. Draining the queue afterwards exposes any reordering, and a hold check exposes output that changes while ready is low. Reading the status byte twice separates a flag that never clears from one that clears before it is reported. A second delayed write sent while the sequencer is stalled must be dropped, not allowed to overwrite the byte already offered. The bench also watches the register bus while the write strobe is held low, which catches a design that commits on the falling strobe. Strobes sent with chip select high must change neither the index nor the output enable.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic rd_n;
    logic a0;
  } hpb_ctl_t;

  localparam int ST_IDLE = 0;
  localparam int ST_FULL = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_OVF  = 3;
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hpb_fifo.sv
module hpb_fifo #(
  parameter int W = 15,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         empty,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         pop;

  assign full  = (wp - rp) == DEPTH_C;
  assign empty = (wp == rp);
  assign pop   = !empty && (!out_valid || out_ready);

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= push_data;
  end

  // registered read port doubles as the output stage
  always_ff @(posedge clk) begin
    if (pop) out_data <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop) begin
        rp        <= rp + 1'b1;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hpb_seq_slot.sv
module hpb_seq_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         drop,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] data
);
  logic can_take;

  assign can_take = !valid || ready;
  assign drop     = load && !can_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load && can_take) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/host_port_bridge.sv
module host_port_bridge
  import hpb_pkg::*;
#(
  parameter int DW = 8,
  parameter int IMM_DEPTH = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          a0,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          reg_wr_valid,
  input  logic          reg_wr_ready,
  output logic [DW-2:0] reg_wr_addr,
  output logic [DW-1:0] reg_wr_data,
  output logic [DW-2:0] reg_rd_addr,
  input  logic [DW-1:0] reg_rd_data,
  output logic          seq_valid,
  input  logic          seq_ready,
  output logic [DW-1:0] seq_data
);
  localparam int RA_W = DW - 1;
  localparam int QW   = RA_W + DW;
  localparam int CW   = $bits(hpb_ctl_t);

  hpb_ctl_t      ctl_raw, c2, c3;
  logic [DW-1:0] d2, d3;

  assign ctl_raw = '{cs_n: cs_n, wr_n: wr_n, rd_n: rd_n, a0: a0};

  hpb_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL({CW{1'b1}})) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(c2)
  );

  hpb_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst(rst), .d(bus_din), .q(d2)
  );

  // one more stage to see edges and hold the values seen before them
  always_ff @(posedge clk) begin
    if (rst) begin
      c3 <= '1;
      d3 <= '0;
    end else begin
      c3 <= c2;
      d3 <= d2;
    end
  end

  logic wr_commit, rd_start;
  assign wr_commit = c2.wr_n && !c3.wr_n && !c3.cs_n;
  assign rd_start  = !c2.rd_n && c3.rd_n && !c2.cs_n;

  logic [DW-1:0] idx_q;
  logic          path_dly;
  assign path_dly    = idx_q[DW-1];
  assign reg_rd_addr = idx_q[RA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (wr_commit && !c3.a0) idx_q <= d3;
  end

  logic imm_push, dly_push;
  assign imm_push = wr_commit && c3.a0 && !path_dly;
  assign dly_push = wr_commit && c3.a0 && path_dly;

  logic          fifo_full, fifo_empty;
  logic [QW-1:0] q_out;

  hpb_fifo #(.W(QW), .DEPTH(IMM_DEPTH)) u_imm_q (
    .clk(clk), .rst(rst),
    .push(imm_push), .push_data({idx_q[RA_W-1:0], d3}),
    .full(fifo_full), .empty(fifo_empty),
    .out_valid(reg_wr_valid), .out_ready(reg_wr_ready),
    .out_data(q_out)
  );

  assign reg_wr_addr = q_out[QW-1:DW];
  assign reg_wr_data = q_out[DW-1:0];

  logic dly_drop;

  hpb_seq_slot #(.W(DW)) u_dly_slot (
    .clk(clk), .rst(rst),
    .load(dly_push), .load_data(d3), .drop(dly_drop),
    .valid(seq_valid), .ready(seq_ready), .data(seq_data)
  );

  logic imm_drop, ovf_q;
  assign imm_drop = imm_push && fifo_full;

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else if (imm_drop || dly_drop) ovf_q <= 1'b1;
    else if (rd_start && !c2.a0) ovf_q <= 1'b0;
  end

  logic [DW-1:0] status;
  always_comb begin
    status          = '0;
    status[ST_IDLE] = fifo_empty && !reg_wr_valid;
    status[ST_FULL] = fifo_full;
    status[ST_BUSY] = seq_valid || !seq_ready;
    status[ST_OVF]  = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dout <= '0;
      bus_oe   <= 1'b0;
    end else begin
      bus_oe <= !c2.cs_n && !c2.rd_n;
      if (rd_start) bus_dout <= c2.a0 ? reg_rd_data : status;
    end
  end
endmodule

// File: rtl/host_port_bridge_chk.sv
module host_port_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          rd_n,
  input logic          a0,
  input logic          bus_oe,
  input logic          reg_wr_valid,
  input logic          reg_wr_ready,
  input logic [DW-2:0] reg_wr_addr,
  input logic [DW-1:0] reg_wr_data,
  input logic          seq_valid,
  input logic          seq_ready,
  input logic [DW-1:0] seq_data,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          ovf_q
);
  p_oe_select_r10: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(!cs_n && !rd_n, 3));

  p_imm_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_valid && !reg_wr_ready) |=>
      (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data)));

  p_seq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_valid && !seq_ready) |=> (seq_valid && $stable(seq_data)));

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  p_ovf_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> ($past(fifo_full) || $past(seq_valid)));

  p_ovf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_q) |-> $past(!cs_n && !rd_n && !a0, 3));
endmodule

bind host_port_bridge host_port_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .a0(a0),
  .bus_oe(bus_oe), .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
  .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
  .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_data(seq_data),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .ovf_q(ovf_q)
);

// File: tb/test_host_port_bridge.sv
module test_host_port_bridge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic       reg_wr_valid;
  logic       reg_wr_ready = 1'b1;
  logic [6:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic [6:0] reg_rd_addr;
  logic [7:0] reg_rd_data;
  logic       seq_valid;
  logic       seq_ready = 1'b1;
  logic [7:0] seq_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // register file model used as read source
  always_comb reg_rd_data = {reg_rd_addr, 1'b0} ^ 8'h5A;

  host_port_bridge i_host_port_bridge (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .a0(a0),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_data(seq_data)
  );

  logic [14:0] imm_log [100];
  int          imm_n = 0;
  logic [7:0]  seq_log [16];
  int          seq_n = 0;

  always @(negedge clk) begin
    if (!rst && reg_wr_valid && reg_wr_ready && imm_n < 100) begin
      imm_log[imm_n] = {reg_wr_addr, reg_wr_data};
      imm_n++;
    end
    if (!rst && seq_valid && seq_ready && seq_n < 16) begin
      seq_log[seq_n] = seq_data;
      seq_n++;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_wr(input logic adr, input logic [7:0] d);
    cyc(1);
    cs_n = 1'b0; a0 = adr; bus_din = d;
    cyc(2); wr_n = 1'b0;
    cyc(4); wr_n = 1'b1;
    cyc(2); cs_n = 1'b1;
    cyc(6);
  endtask

  task automatic host_rd(input logic adr, output logic [7:0] d);
    cyc(1);
    cs_n = 1'b0; a0 = adr;
    cyc(2); rd_n = 1'b0;
    cyc(6);
    @(negedge clk);
    check("R10 oe during read", {15'd0, bus_oe}, 16'd1);
    d = bus_dout;
    cyc(1); rd_n = 1'b1;
    cyc(2); cs_n = 1'b1;
    cyc(6);
    @(negedge clk);
    check("R10 oe after read", {15'd0, bus_oe}, 16'd0);
  endtask

  function automatic logic [7:0] fill_byte(input int i);
    return 8'((i * 3) + 7);
  endfunction

  task automatic t_reset;
    logic [7:0] st;
    @(negedge clk);
    check("R1 bus_oe", {15'd0, bus_oe}, 16'd0);
    check("R1 reg_wr_valid", {15'd0, reg_wr_valid}, 16'd0);
    check("R1 seq_valid", {15'd0, seq_valid}, 16'd0);
    host_rd(1'b0, st);
    check("R1 R12 status after reset", {8'd0, st}, 16'h01);
  endtask

  task automatic t_index_read;
    logic [7:0] v;
    host_wr(1'b0, 8'h15);
    @(negedge clk);
    check("R2 reg_rd_addr", {9'd0, reg_rd_addr}, 16'h15);
    host_rd(1'b1, v);
    check("R9 data read", {8'd0, v}, {8'd0, 8'h2A ^ 8'h5A});
  endtask

  task automatic t_commit_edge;
    int base;
    base = imm_n;
    cyc(1);
    cs_n = 1'b0; a0 = 1'b1; bus_din = 8'hA5;
    cyc(2); wr_n = 1'b0;
    cyc(10);
    @(negedge clk);
    check("R11 nothing while strobe low", 16'(imm_n - base), 16'd0);
    cyc(1); wr_n = 1'b1;
    cyc(2); cs_n = 1'b1;
    cyc(8);
    check("R3 R11 one write after rise", 16'(imm_n - base), 16'd1);
    check("R3 addr and data", {1'b0, imm_log[base]}, {1'b0, 7'h15, 8'hA5});
  endtask

  task automatic t_no_select;
    cyc(1);
    a0 = 1'b0; bus_din = 8'h33;
    cyc(2); wr_n = 1'b0;
    cyc(4); wr_n = 1'b1;
    cyc(2); rd_n = 1'b0;
    cyc(6);
    @(negedge clk);
    check("R10 oe stays low without select", {15'd0, bus_oe}, 16'd0);
    cyc(1); rd_n = 1'b1;
    cyc(4);
    check("R10 index unchanged without select", {9'd0, reg_rd_addr}, 16'h15);
  endtask

  task automatic t_fill;
    int base;
    logic [7:0] st;
    base = imm_n;
    reg_wr_ready = 1'b0;
    for (int i = 0; i < 66; i++) host_wr(1'b1, fill_byte(i));
    @(negedge clk);
    check("R3 held while not ready", {7'd0, reg_wr_valid, reg_wr_data}, {7'd0, 1'b1, fill_byte(0)});
    check("R3 nothing delivered while stalled", 16'(imm_n - base), 16'd0);
    host_rd(1'b0, st);
    check("R4 R5 R12 status full and overflow", {8'd0, st}, 16'h0A);
    host_rd(1'b0, st);
    check("R6 overflow cleared by status read", {8'd0, st}, 16'h02);
    cyc(1); reg_wr_ready = 1'b1;
    cyc(120);
    check("R4 R5 delivered count", 16'(imm_n - base), 16'd65);
    for (int i = 0; i < 65; i++)
      check("R3 R4 order", {1'b0, imm_log[base + i]}, {1'b0, 7'h15, fill_byte(i)});
    host_rd(1'b0, st);
    check("R12 idle after drain", {8'd0, st}, 16'h01);
  endtask

  task automatic t_delayed;
    int ibase;
    logic [7:0] st;
    ibase = imm_n;
    cyc(1); seq_ready = 1'b0;
    host_wr(1'b0, 8'h80);
    host_wr(1'b1, 8'hC3);
    @(negedge clk);
    check("R7 seq_valid", {15'd0, seq_valid}, 16'd1);
    check("R7 seq_data", {8'd0, seq_data}, 16'hC3);
    host_wr(1'b1, 8'h3C);
    @(negedge clk);
    check("R8 held byte not overwritten", {8'd0, seq_data}, 16'hC3);
    host_rd(1'b0, st);
    check("R8 status busy and overflow", {8'd0, st}, 16'h0D);
    cyc(1); seq_ready = 1'b1;
    cyc(6);
    check("R7 one byte accepted", 16'(seq_n), 16'd1);
    check("R7 accepted byte", {8'd0, seq_log[0]}, 16'hC3);
    check("R7 nothing on register bus", 16'(imm_n - ibase), 16'd0);
    check("R7 slot empty", {15'd0, seq_valid}, 16'd0);
    host_rd(1'b0, st);
    check("R8 R12 status after accept", {8'd0, st}, 16'h01);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_index_read();
    t_commit_edge();
    t_no_select();
    t_fill();
    t_delayed();
    done = 1'b1;
    finish_run();
  end
endmodule